// File: doc/BRIEF.md
# Permuted Tile Address Generator

This block produces the address pairs needed to copy one tile of 32 lanes from a column-major matrix in main memory into a scratchpad whose layout is swizzled. Each lane moves one 128-bit word. For every lane the block emits the lane number, a source offset into main memory, and a destination offset into the scratchpad. The source offset follows the plain column-major stride. The destination offset mixes the lane's group bits and row bits with an XOR, so that each set of eight simultaneous 128-bit stores lands in eight different bank groups.

A single-cycle start strobe launches a sequence and captures both leading dimensions. The block then presents four phases on consecutive cycles, with eight lanes per phase. Phase p carries lanes 8p to 8p+7. The last phase raises a done flag. All offsets are counted in 128-bit units. A bank group is the offset modulo 8.

Top module: `perm_tile_agen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with no start, `valid_o` and `done_o` are 0.
- R2: A start sampled while idle gives exactly four consecutive cycles with `valid_o` high, beginning on the next cycle, with `phase_o` taking the values 0, 1, 2 and 3 in that order. `valid_o` is 0 in the following cycle.
- R3: `done_o` is 1 only in the cycle where `valid_o` is 1 and `phase_o` is 3.
- R4: Lane slot k (0..7), which occupies bits [5k+4:5k] of `lane_o`, carries lane number 8*phase+k.
- R5: With c = lane mod 8 and s = lane / 8, the source offset in slot k of `gofs_o` (bits [19k+18:19k]) equals c + s*src_ld.
- R6: The scratchpad offset in slot k of `sofs_o` (bits [19k+18:19k]) equals row*spad_ld + bank. Here row = (c & 1) | ((c >> 1) & 2) and bank = ((c << 1) & 4) | (s XOR row).
- R7: A start strobe that arrives while `valid_o` is high is ignored. The phase order is unchanged and no extra phases follow.
- R8: The leading dimensions used for a whole sequence are the values present on the start cycle. Input changes during the sequence have no effect on the offsets.
- R9: When spad_ld is a multiple of 8, the eight scratchpad offsets within every phase fall into eight distinct bank groups (offset mod 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| src_ld_i | input | 16 | Source leading dimension in 128-bit units |
| spad_ld_i | input | 16 | Scratchpad leading dimension in 128-bit units |
| valid_o | output | 1 | A phase of eight lanes is presented |
| done_o | output | 1 | The presented phase is the last one |
| phase_o | output | 2 | Index of the presented phase |
| lane_o | output | 40 | Eight lane numbers, 5 bits each, slot 0 in the low bits |
| gofs_o | output | 152 | Eight source offsets, 19 bits each |
| sofs_o | output | 152 | Eight scratchpad offsets, 19 bits each |

## Verification
The case hardest to reach from the ports is a start strobe that arrives together with new leading dimensions in the middle of a running sequence. In that case the design must neither restart nor take up the new strides. The stimulus holds start high across the inner phases while changing both leading dimensions. The expected entries stay based on the values captured at the start, and after the fourth phase the bench confirms that no further phase appears. Bank-group distinctness is checked on every phase whenever the scratchpad stride is a multiple of 8, including the largest stride that fits in 16 bits.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

    localparam int LD_W       = 16;
    localparam int OFF_W      = LD_W + 3;
    localparam int SLOTS      = 8;
    localparam int PHASES     = 4;
    localparam int LANE_W     = $clog2(SLOTS * PHASES);
    localparam int PH_W       = $clog2(PHASES);
    localparam int COL_W      = $clog2(SLOTS);
    localparam int BANK_GROUPS = 8;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [LD_W-1:0]   ld_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        off_t              gofs;
        off_t              sofs;
    } lane_addr_t;

    // Scratchpad row: column bit 0 stays, column bit 2 moves to bit 1.
    function automatic logic [1:0] row_of(input col_t c);
        return {c[2], c[0]};
    endfunction

    // Bank group: column bit 1 picks the upper half, the group index is
    // XORed with the row in the lower two bits.
    function automatic logic [2:0] bank_of(input col_t c, input phase_t s);
        logic [1:0] r;
        r = row_of(c);
        return {c[1], s ^ r};
    endfunction

endpackage

// File: rtl/ptag_seq.sv
module ptag_seq
    import ptag_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   start_i,
    input  ld_t    src_ld_i,
    input  ld_t    spad_ld_i,
    output logic   busy_o,
    output phase_t phase_o,
    output ld_t    src_ld_q_o,
    output ld_t    spad_ld_q_o
);
    localparam phase_t LAST_PHASE = phase_t'(PHASES - 1);

    seq_state_e state_q;
    phase_t     phase_q;
    ld_t        src_q;
    ld_t        spad_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_IDLE;
            phase_q <= '0;
            src_q   <= '0;
            spad_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_RUN;
                        phase_q <= '0;
                        src_q   <= src_ld_i;
                        spad_q  <= spad_ld_i;
                    end
                end
                SEQ_RUN: begin
                    if (phase_q == LAST_PHASE) begin
                        state_q <= SEQ_IDLE;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q == SEQ_RUN);
    assign phase_o     = phase_q;
    assign src_ld_q_o  = src_q;
    assign spad_ld_q_o = spad_q;
endmodule

// File: rtl/ptag_lane.sv
module ptag_lane
    import ptag_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  phase_t     phase_i,
    input  ld_t        src_ld_i,
    input  ld_t        spad_ld_i,
    output lane_addr_t addr_o
);
    localparam col_t COL = col_t'(SLOT);

    logic [1:0] row;
    logic [2:0] bank;
    off_t       g_stride;
    off_t       s_stride;

    always_comb begin
        row      = row_of(COL);
        bank     = bank_of(COL, phase_i);
        g_stride = off_t'(src_ld_i) * off_t'(phase_i);
        s_stride = off_t'(spad_ld_i) * off_t'(row);
        addr_o.lane = {phase_i, COL};
        addr_o.gofs = g_stride + off_t'(COL);
        addr_o.sofs = s_stride + off_t'(bank);
    end
endmodule

// File: rtl/perm_tile_agen.sv
module perm_tile_agen
    import ptag_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      start_i,
    input  logic [LD_W-1:0]           src_ld_i,
    input  logic [LD_W-1:0]           spad_ld_i,
    output logic                      valid_o,
    output logic                      done_o,
    output logic [PH_W-1:0]           phase_o,
    output logic [SLOTS*LANE_W-1:0]   lane_o,
    output logic [SLOTS*OFF_W-1:0]    gofs_o,
    output logic [SLOTS*OFF_W-1:0]    sofs_o
);
    localparam phase_t LAST_PHASE = phase_t'(PHASES - 1);

    logic   busy;
    phase_t phase;
    ld_t    src_ld_q;
    ld_t    spad_ld_q;

    ptag_seq u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .src_ld_i   (src_ld_i),
        .spad_ld_i  (spad_ld_i),
        .busy_o     (busy),
        .phase_o    (phase),
        .src_ld_q_o (src_ld_q),
        .spad_ld_q_o(spad_ld_q)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        lane_addr_t addr;
        ptag_lane #(.SLOT(k)) u_lane (
            .phase_i  (phase),
            .src_ld_i (src_ld_q),
            .spad_ld_i(spad_ld_q),
            .addr_o   (addr)
        );
        assign lane_o[k*LANE_W +: LANE_W] = addr.lane;
        assign gofs_o[k*OFF_W  +: OFF_W]  = addr.gofs;
        assign sofs_o[k*OFF_W  +: OFF_W]  = addr.sofs;
    end

    assign valid_o = busy;
    assign done_o  = busy && (phase == LAST_PHASE);
    assign phase_o = phase;
endmodule

// File: rtl/ptag_chk.sv
module ptag_chk
    import ptag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              valid,
    input logic              done,
    input logic [PH_W-1:0]   phase,
    input logic [LANE_W-1:0] lane0,
    input logic [3*SLOTS-1:0] banks,
    input logic [LD_W-1:0]   spad_ld_q
);
    logic [BANK_GROUPS-1:0] hit;

    always_comb begin
        hit = '0;
        for (int k = 0; k < SLOTS; k++) begin
            hit[banks[k*3 +: 3]] = 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !valid && !done);

    assert_first_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> phase == '0);

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        valid && phase != PH_W'(PHASES - 1) |=> valid && phase == $past(phase) + 1'b1);

    assert_done_last_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> valid && phase == PH_W'(PHASES - 1));

    assert_done_ends_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !valid);

    assert_lane_base_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> lane0 == {phase, 3'b000});

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        valid && start && phase != PH_W'(PHASES - 1) |=> phase != '0);

    assert_ld_hold_R8: assert property (@(posedge clk) disable iff (rst)
        valid && phase != '0 |-> $stable(spad_ld_q));

    assert_banks_distinct_R9: assert property (@(posedge clk) disable iff (rst)
        valid && spad_ld_q[2:0] == 3'b000 |-> $countones(hit) == BANK_GROUPS);
endmodule

bind perm_tile_agen ptag_chk u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .start    (start_i),
    .valid    (valid_o),
    .done     (done_o),
    .phase    (phase_o),
    .lane0    (lane_o[4:0]),
    .banks    ({sofs_o[7*19 +: 3], sofs_o[6*19 +: 3], sofs_o[5*19 +: 3],
                sofs_o[4*19 +: 3], sofs_o[3*19 +: 3], sofs_o[2*19 +: 3],
                sofs_o[1*19 +: 3], sofs_o[0 +: 3]}),
    .spad_ld_q(spad_ld_q)
);

// File: tb/tb_perm_tile_agen.sv
module tb_perm_tile_agen;

    localparam int OW = 19;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   src_ld = '0;
    logic [15:0]   spad_ld = '0;
    logic          valid, done;
    logic [1:0]    phase;
    logic [8*LW-1:0] lane;
    logic [8*OW-1:0] gofs, sofs;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    typedef struct {
        int ph;
        int lane [8];
        int g [8];
        int s [8];
        bit chk_bank;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    perm_tile_agen dut (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .src_ld_i(src_ld), .spad_ld_i(spad_ld),
        .valid_o(valid), .done_o(done), .phase_o(phase),
        .lane_o(lane), .gofs_o(gofs), .sofs_o(sofs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_tile(input int lda, input int ldm);
        for (int p = 0; p < 4; p++) begin
            exp_t e;
            e.ph = p;
            for (int k = 0; k < 8; k++) begin
                int row, bank;
                row  = (k & 1) | ((k >> 1) & 2);
                bank = ((k << 1) & 4) | (p ^ row);
                e.lane[k] = 8 * p + k;
                e.g[k]    = k + p * lda;
                e.s[k]    = row * ldm + bank;
            end
            e.chk_bank = (ldm % 8) == 0;
            q.push_back(e);
        end
    endtask

    task automatic settle_idle();
        repeat (6) @(negedge clk);
        @(posedge clk);
        #2;
        check(valid == 1'b0, "R2", int'(valid), 0);
        check(q.size() == 0, "R2", q.size(), 0);
    endtask

    task automatic run_tile(input int lda, input int ldm);
        push_tile(lda, ldm);
        @(negedge clk);
        start = 1'b1; src_ld = 16'(lda); spad_ld = 16'(ldm);
        @(negedge clk);
        start = 1'b0;
        settle_idle();
    endtask

    // Monitor: compares each presented phase with the head of the queue
    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7", int'(phase), -1);
                end else begin
                    exp_t e;
                    bit [7:0] hit;
                    e = q.pop_front();
                    hit = '0;
                    check(int'(phase) == e.ph, "R2", int'(phase), e.ph);
                    check(done == (e.ph == 3), "R3", int'(done), int'(e.ph == 3));
                    for (int k = 0; k < 8; k++) begin
                        int la, ga, sa;
                        la = int'(lane[k*LW +: LW]);
                        ga = int'(gofs[k*OW +: OW]);
                        sa = int'(sofs[k*OW +: OW]);
                        check(la == e.lane[k], "R4", la, e.lane[k]);
                        check(ga == e.g[k], "R5/R8", ga, e.g[k]);
                        check(sa == e.s[k], "R6/R8", sa, e.s[k]);
                        hit[sa % 8] = 1'b1;
                    end
                    if (e.chk_bank)
                        check($countones(hit) == 8, "R9", $countones(hit), 8);
                end
            end else begin
                check(done == 1'b0, "R3", int'(done), 0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1", int'(valid), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(valid == 1'b0, "R1", int'(valid), 0);

        run_tile(64, 8);
        run_tile(1000, 40);
        run_tile(65535, 65528);
        run_tile(0, 0);
        run_tile(3, 13);
        run_tile(7, 16);

        // R7 and R8: a start strobe with new strides during a running sequence
        push_tile(17, 24);
        @(negedge clk);
        start = 1'b1; src_ld = 16'd17; spad_ld = 16'd24;
        @(negedge clk);
        src_ld = 16'd999; spad_ld = 16'd77;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        settle_idle();
        src_ld = 16'd5; spad_ld = 16'd32;

        run_tile(5, 32);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule